// File: doc/BRIEF.md
# Vector predicate mask generator

This block turns a small predicate-select code into a 64-bit element-enable mask for a vectorised instruction. The mask comes from one of two kinds of source. An integer predicate is taken from one of three fixed general-purpose register values. The value can be used as it is, bit-inverted, or turned into a one-hot mask by shifting a single 1 left. A condition-register predicate gathers one chosen bit from each of the 4-bit condition fields 0 to VL-1, inverts it if the code asks for that, and places it at the element position that matches the field.

The instruction decoder presents the code, the kind flag, the register values already read, the flattened condition fields and the vector length, and pulses a valid strobe. The mask is registered. It appears on the first clock edge that samples the strobe high and holds until the next strobe.

Top module: `pred_mask_gen`

## Requirements
- R1: While reset (active low) is asserted, and after it is released until the first strobe, the mask output is all zeros.
- R2: The mask output takes a new value at the clock edge that samples `in_valid` high. When `in_valid` is low it keeps its value, whatever the other inputs do.
- R3: With `pred_cr`=0 and `pred_code`=0 (always), the mask is 64 ones.
- R4: With `pred_cr`=0 and `pred_code`=1, the mask is 1 shifted left by `reg3[5:0]`. The upper bits of `reg3` are ignored.
- R5: With `pred_cr`=0, codes 2, 4 and 6 give `reg3`, `reg10` and `reg30` unchanged. Codes 3, 5 and 7 give the bitwise inverse of the same registers.
- R6: With `pred_cr`=1, code bits [2:1] choose the bit index within a condition field and code bit 0 inverts the selected bit. This gives LT=0, GE=1 on index 0; GT=2, LE=3 on index 1; EQ=4, NE=5 on index 2; SO=6, NS=7 on index 3. Bit i of field f is `cr_fields[4*f+i]`.
- R7: In a condition-register mask, element e comes from field e. Elements at positions VL and above are 0. A VL of 64 or more fills all 64 elements, and a VL of 0 gives an all-zero mask.
- R8: Any code from 8 to 15 gives an all-zero mask, for either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: compute and register a new mask |
| pred_cr | input | 1 | Predicate kind: 0 integer, 1 condition register |
| pred_code | input | 4 | Predicate select code |
| reg3 | input | 64 | Value of general-purpose register 3 |
| reg10 | input | 64 | Value of general-purpose register 10 |
| reg30 | input | 64 | Value of general-purpose register 30 |
| cr_fields | input | 256 | Condition fields 0..63, 4 bits each, field f at [4f+3:4f] |
| vl | input | 7 | Vector length, 0..127 (values above 64 act as 64) |
| mask_o | output | 64 | Registered element-enable mask |

## Verification
Every mask is due exactly one clock edge after the strobe: there is one register between the inputs and `mask_o`. The bench drives the inputs on a falling edge with `in_valid` high. It drops the strobe and compares the output on the next falling edge, after the single rising edge that loads the register. For hold checks it drives new operands with the strobe low and checks on the next falling edge that the output has not moved.

// File: rtl/pred_mask_pkg.sv
package pred_mask_pkg;

    // integer predicate select codes
    localparam logic [3:0] IP_ALWAYS    = 4'd0;
    localparam logic [3:0] IP_R3_ONEHOT = 4'd1;
    localparam logic [3:0] IP_R3        = 4'd2;
    localparam logic [3:0] IP_R3_INV    = 4'd3;
    localparam logic [3:0] IP_R10       = 4'd4;
    localparam logic [3:0] IP_R10_INV   = 4'd5;
    localparam logic [3:0] IP_R30       = 4'd6;
    localparam logic [3:0] IP_R30_INV   = 4'd7;

    typedef struct packed {
        logic       ok;     // code is a known condition code
        logic [1:0] idx;    // bit index inside a condition field
        logic       flip;   // invert the selected bit
    } cr_sel_t;

    // condition code: pairs share an index, the odd member inverts
    function automatic cr_sel_t cr_sel_decode(input logic [3:0] code);
        cr_sel_t s;
        s.ok   = ~code[3];
        s.idx  = code[2:1];
        s.flip = code[0];
        return s;
    endfunction

endpackage

// File: rtl/pm_int_sel.sv
module pm_int_sel #(
    parameter int MASK_W = 64,
    localparam int SH_W = $clog2(MASK_W)
) (
    input  logic [3:0]        code,
    input  logic [MASK_W-1:0] r3,
    input  logic [MASK_W-1:0] r10,
    input  logic [MASK_W-1:0] r30,
    output logic [MASK_W-1:0] mask
);
    import pred_mask_pkg::*;

    always_comb begin
        unique case (code)
            IP_ALWAYS:    mask = '1;
            IP_R3_ONEHOT: mask = MASK_W'(1) << r3[SH_W-1:0];
            IP_R3:        mask = r3;
            IP_R3_INV:    mask = ~r3;
            IP_R10:       mask = r10;
            IP_R10_INV:   mask = ~r10;
            IP_R30:       mask = r30;
            IP_R30_INV:   mask = ~r30;
            default:      mask = '0;
        endcase
    end
endmodule

// File: rtl/pm_cr_gather.sv
module pm_cr_gather #(
    parameter int MASK_W  = 64,
    parameter int FIELD_W = 4,
    localparam int VL_W   = $clog2(MASK_W + 1),
    localparam int CR_W   = MASK_W * FIELD_W
) (
    input  logic [3:0]        code,
    input  logic [CR_W-1:0]   fields,
    input  logic [VL_W-1:0]   vl,
    output logic [MASK_W-1:0] mask
);
    import pred_mask_pkg::*;

    cr_sel_t sel;
    assign sel = cr_sel_decode(code);

    for (genvar e = 0; e < MASK_W; e++) begin : g_elem
        localparam logic [VL_W-1:0] POS = VL_W'(e);
        logic [FIELD_W-1:0] fld;
        logic               in_range;
        assign fld      = fields[e*FIELD_W +: FIELD_W];
        assign in_range = POS < vl;
        assign mask[e]  = sel.ok & in_range & (fld[sel.idx] ^ sel.flip);
    end
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen #(
    parameter int MASK_W  = 64,
    parameter int FIELD_W = 4,
    localparam int VL_W   = $clog2(MASK_W + 1),
    localparam int CR_W   = MASK_W * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              pred_cr,
    input  logic [3:0]        pred_code,
    input  logic [MASK_W-1:0] reg3,
    input  logic [MASK_W-1:0] reg10,
    input  logic [MASK_W-1:0] reg30,
    input  logic [CR_W-1:0]   cr_fields,
    input  logic [VL_W-1:0]   vl,
    output logic [MASK_W-1:0] mask_o
);
    localparam logic [VL_W-1:0] VL_MAX = VL_W'(MASK_W);

    typedef struct packed {
        logic [MASK_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;
    logic [MASK_W-1:0] int_mask, cr_mask;
    logic [VL_W-1:0]   vl_eff;

    assign vl_eff = (vl > VL_MAX) ? VL_MAX : vl;

    pm_int_sel #(.MASK_W(MASK_W)) u_int (
        .code (pred_code),
        .r3   (reg3),
        .r10  (reg10),
        .r30  (reg30),
        .mask (int_mask)
    );

    pm_cr_gather #(.MASK_W(MASK_W), .FIELD_W(FIELD_W)) u_cr (
        .code   (pred_code),
        .fields (cr_fields),
        .vl     (vl_eff),
        .mask   (cr_mask)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.mask = pred_cr ? cr_mask : int_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/pred_mask_chk.sv
module pred_mask_chk #(
    parameter int MASK_W = 64,
    localparam int VL_W  = $clog2(MASK_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              pred_cr,
    input logic [3:0]        pred_code,
    input logic [VL_W-1:0]   vl,
    input logic [MASK_W-1:0] mask_o
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(mask_o));

    a_r3_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred_cr && pred_code == 4'd0) |=> (mask_o == '1));

    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred_cr && pred_code == 4'd1) |=> ($countones(mask_o) == 1));

    a_r7_above_vl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_cr && vl < VL_W'(MASK_W)) |=> ((mask_o >> $past(vl)) == '0));

    a_r8_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_code[3]) |=> (mask_o == '0));
endmodule

bind pred_mask_gen pred_mask_chk #(.MASK_W(MASK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pred_cr   (pred_cr),
    .pred_code (pred_code),
    .vl        (vl),
    .mask_o    (mask_o)
);

// File: tb/sim_pred_mask_gen.sv
module sim_pred_mask_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         pred_cr = 1'b0;
    logic [3:0]   pred_code = '0;
    logic [63:0]  reg3 = '0, reg10 = '0, reg30 = '0;
    logic [255:0] cr_fields = '0;
    logic [6:0]   vl = '0;
    logic [63:0]  mask_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_mask_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred_cr(pred_cr),
        .pred_code(pred_code), .reg3(reg3), .reg10(reg10), .reg30(reg30),
        .cr_fields(cr_fields), .vl(vl), .mask_o(mask_o)
    );

    function automatic logic [63:0] ref_mask(input logic kind, input logic [3:0] code,
            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
            input logic [255:0] cr, input logic [6:0] len);
        logic [63:0] m;
        int lim;
        m = '0;
        if (code >= 4'd8) return '0;                        // R8
        if (!kind) begin
            case (code)
                4'd0: m = {64{1'b1}};                       // R3
                4'd1: m = 64'd1 << a[5:0];                  // R4
                4'd2: m = a;   4'd3: m = ~a;                // R5
                4'd4: m = b;   4'd5: m = ~b;
                4'd6: m = c;   4'd7: m = ~c;
                default: m = '0;
            endcase
        end else begin
            lim = (len > 7'd64) ? 64 : int'(len);           // R7
            for (int e = 0; e < lim; e++)                   // R6
                m[e] = cr[4*e + int'(code[2:1])] ^ code[0];
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        n_run++;
        if (mask_o !== exp) begin
            n_fail++;
            $display("FAIL %s: mask got %h expected %h", req, mask_o, exp);
        end
    endtask

    // strobe one request and check the registered result one edge later
    task automatic apply(input string req, input logic kind, input logic [3:0] code,
            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
            input logic [255:0] cr, input logic [6:0] len);
        @(negedge clk);
        in_valid = 1'b1; pred_cr = kind; pred_code = code;
        reg3 = a; reg10 = b; reg30 = c; cr_fields = cr; vl = len;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, ref_mask(kind, code, a, b, c, cr, len));
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [255:0] r256();
        return {r64(), r64(), r64(), r64()};
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] a, b, c, held;
        logic [255:0] cr;
        void'($urandom(32'd20240));
        a = 64'hF0F0_1234_5678_9ABC; b = 64'h0123_4567_89AB_CDEF; c = 64'h8000_0000_0000_0001;
        cr = r256();

        // R1: reset value, during and just after reset
        repeat (2) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);

        apply("R3", 1'b0, 4'd0, a, b, c, cr, 7'd0);
        apply("R4", 1'b0, 4'd1, 64'hFFFF_FFFF_FFFF_FFC0, b, c, cr, 7'd5);  // shift 0
        apply("R4", 1'b0, 4'd1, 64'h0000_0000_0000_007F, b, c, cr, 7'd5);  // shift 63
        apply("R4", 1'b0, 4'd1, 64'h1234_0000_0000_0025, b, c, cr, 7'd5);
        for (int k = 2; k < 8; k++) apply("R5", 1'b0, 4'(k), a, b, c, cr, 7'd9);

        // R6 every condition code at full length
        for (int k = 0; k < 8; k++) apply("R6", 1'b1, 4'(k), a, b, c, cr, 7'd64);
        // R7 length corners
        apply("R7", 1'b1, 4'd1, a, b, c, '0, 7'd0);
        apply("R7", 1'b1, 4'd1, a, b, c, '0, 7'd5);
        apply("R7", 1'b1, 4'd0, a, b, c, '1, 7'd63);
        apply("R7", 1'b1, 4'd7, a, b, c, '0, 7'd100);
        apply("R7", 1'b1, 4'd4, a, b, c, cr, 7'd1);
        // R8 unknown codes
        apply("R8", 1'b0, 4'd8, a, b, c, cr, 7'd64);
        apply("R8", 1'b0, 4'd15, a, b, c, cr, 7'd64);
        apply("R8", 1'b1, 4'd9, a, b, c, '1, 7'd64);

        // R2: changing operands without a strobe leaves the mask unchanged
        apply("R2", 1'b0, 4'd2, a, b, c, cr, 7'd3);
        held = a;
        @(negedge clk);
        pred_code = 4'd0; reg3 = ~a; pred_cr = 1'b1; vl = 7'd64;
        @(negedge clk);
        check("R2", held);
        @(negedge clk);
        check("R2", held);

        // random mix, both kinds, all codes
        for (int i = 0; i < 400; i++)
            apply("R5/R6 random", 1'($urandom), 4'($urandom), r64(), r64(), r64(),
                  r256(), 7'($urandom_range(0, 70)));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule